// File: doc/BRIEF.md
# Multiplierless 8-point forward integer DCT

This block takes one column of eight signed samples per clock and returns its eight integer DCT coefficients one cycle later, using the integer kernel of the current high-efficiency video standard. It contains no general multiplier. A sum/difference stage folds the column in half. The sums feed a nested 4-point transform that yields the even coefficients. Each difference goes to a single shift-add unit that makes every constant product the odd rows need, and a two-level adder tree combines those products under fixed signs.

Results are kept at full precision. Each output is ten bits wider than an input, so no input column can overflow it. Scaling and rounding belong to the stage that follows. The block is meant to sit in a row/column 2-D transform or to be used as a 1-D stage on its own. A new column can be accepted on every cycle.

Top module: `dct8_fwd`

## Requirements
- R1: The datapath folds the column as a(i) = x(i) + x(7-i) and b(i) = x(i) - x(7-i), for i = 0..3. A column that mirrors about its centre therefore gives zero odd coefficients, and an anti-mirrored column gives zero even coefficients.
- R2: Inputs are two's complement, with lane i of x_i at bits [i*DATA_W +: DATA_W]. Output lane k of y_o sits at bits [k*(DATA_W+10) +: DATA_W+10]. Lanes 0, 2, 4 and 6 equal the 4-point transform of a(0..3) with rows (64,64,64,64), (83,36,-36,-83), (64,-64,-64,64) and (36,-83,83,-36).
- R3: Lanes 1, 3, 5 and 7 equal b(0..3) multiplied by the rows (89,75,50,18), (75,-18,-89,-50), (50,-89,18,75) and (18,-50,75,-89).
- R4: Every output is DATA_W+10 bits signed and exact. Columns built from the most positive and most negative input values give the exact mathematical result with no wrap.
- R5: valid_o is valid_i delayed by one clock, and y_o holds the coefficients of the column presented with that valid_i.
- R6: When valid_i is low, y_o keeps its previous value, whatever x_i carries.
- R7: While rst_ni is low, valid_o is 0 and every lane of y_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Column on x_i is valid |
| x_i | input | 8*DATA_W | Eight signed input samples, lane i = x(i) |
| valid_o | output | 1 | Coefficients on y_o are valid |
| y_o | output | 8*(DATA_W+10) | Eight signed coefficients, lane k = y(k) |

## Verification
The assertions check several relations on every cycle. The fold sums and differences always add to twice the sample. The two 64-weighted even coefficients sum to 128·(a0+a3). Each shift-add unit's products differ by the expected constant multiples. valid_o follows valid_i with a single cycle of delay, and y_o stays stable when no column is accepted. Whether each coefficient is numerically correct, including its position in the output lanes and exactness at the extreme input values, can only be shown by the bench scenarios. These compare every lane on every clock against a direct 8×8 matrix product.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  localparam int N_PT   = 8;
  localparam int N_HALF = N_PT / 2;
  localparam int GROWTH = 10;  // bits added between input and output

  // Odd row k (output 2k+1), column i: phase (2k+1)(2i+1) mod 32, folded to 0..16
  function automatic int odd_phase(input int k, input int i);
    int m;
    m = ((2 * k + 1) * (2 * i + 1)) % 32;
    if (m > 16) m = 32 - m;
    return m;
  endfunction

  function automatic bit odd_neg(input int k, input int i);
    return odd_phase(k, i) > 8;
  endfunction

  // Product select: 0 -> 89, 1 -> 75, 2 -> 50, 3 -> 18
  function automatic int odd_sel(input int k, input int i);
    int m;
    m = odd_phase(k, i);
    if (m > 8) m = 16 - m;
    return (m - 1) / 2;
  endfunction

endpackage

// File: rtl/dct8_butterfly.sv
module dct8_butterfly #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 26
) (
  input  logic [dct8_pkg::N_PT-1:0][IN_W-1:0]    x_i,
  output logic [dct8_pkg::N_HALF-1:0][ACC_W-1:0] a_o,
  output logic [dct8_pkg::N_HALF-1:0][ACC_W-1:0] b_o
);
  import dct8_pkg::*;

  for (genvar i = 0; i < N_HALF; i++) begin : g_fold
    logic signed [ACC_W-1:0] lo, hi;
    assign lo = ACC_W'($signed(x_i[i]));
    assign hi = ACC_W'($signed(x_i[N_PT-1-i]));
    assign a_o[i] = lo + hi;
    assign b_o[i] = lo - hi;

    always_comb begin
      a_r1_fold_sum: assert (ACC_W'(a_o[i] + b_o[i]) == ACC_W'(lo <<< 1))
        else $error("fold sum/diff mismatch lane %0d", i);
    end
  end

endmodule

// File: rtl/dct8_even4.sv
module dct8_even4 #(
  parameter int ACC_W = 26
) (
  input  logic [3:0][ACC_W-1:0] a_i,
  output logic [3:0][ACC_W-1:0] e_o  // y0, y2, y4, y6
);

  function automatic logic signed [ACC_W-1:0] mul83(input logic signed [ACC_W-1:0] v);
    return (v <<< 6) + (v <<< 4) + (v <<< 1) + v;
  endfunction

  function automatic logic signed [ACC_W-1:0] mul36(input logic signed [ACC_W-1:0] v);
    return (v <<< 5) + (v <<< 2);
  endfunction

  logic signed [ACC_W-1:0] s0, s1, d0, d1;

  assign s0 = a_i[0] + a_i[3];
  assign s1 = a_i[1] + a_i[2];
  assign d0 = a_i[0] - a_i[3];
  assign d1 = a_i[1] - a_i[2];

  // Weight 64 is wiring only
  assign e_o[0] = (s0 + s1) <<< 6;
  assign e_o[2] = (s0 - s1) <<< 6;
  assign e_o[1] = mul83(d0) + mul36(d1);
  assign e_o[3] = mul36(d0) - mul83(d1);

  always_comb begin
    a_r2_dc_nyq_pair: assert (ACC_W'(e_o[0] + e_o[2]) == ACC_W'((a_i[0] + a_i[3]) <<< 7))
      else $error("even pair y0+y4 mismatch");
  end

endmodule

// File: rtl/dct8_mcm.sv
module dct8_mcm #(
  parameter int ACC_W = 26
) (
  input  logic [ACC_W-1:0]      b_i,
  output logic [3:0][ACC_W-1:0] p_o  // 89b, 75b, 50b, 18b
);

  logic signed [ACC_W-1:0] b, b9, b18;

  assign b   = b_i;
  assign b9  = (b <<< 3) + b;          // shared 9b
  assign b18 = (b <<< 4) + (b <<< 1);

  assign p_o[0] = (b <<< 6) + (b <<< 4) + b9;
  assign p_o[1] = (b <<< 6) + (b <<< 1) + b9;
  assign p_o[2] = b18 + (b <<< 5);
  assign p_o[3] = b18;

  always_comb begin
    a_r3_mcm_spread_hi: assert (ACC_W'(p_o[0] - p_o[1]) == ACC_W'((b <<< 4) - (b <<< 1)))
      else $error("89b-75b mismatch");
    a_r3_mcm_spread_lo: assert (ACC_W'(p_o[2] - p_o[3]) == ACC_W'(b <<< 5))
      else $error("50b-18b mismatch");
  end

endmodule

// File: rtl/dct8_odd_sum.sv
module dct8_odd_sum #(
  parameter int ACC_W = 26
) (
  input  logic [3:0][3:0][ACC_W-1:0] p_i,  // [i][sel]: b(i) times 89/75/50/18
  output logic [3:0][ACC_W-1:0]      o_o   // y1, y3, y5, y7
);
  import dct8_pkg::*;

  for (genvar k = 0; k < N_HALF; k++) begin : g_row
    logic signed [3:0][ACC_W-1:0] t;
    logic signed [ACC_W-1:0]      l1_lo, l1_hi;

    for (genvar i = 0; i < N_HALF; i++) begin : g_term
      localparam int SEL = odd_sel(k, i);
      localparam bit NEG = odd_neg(k, i);
      if (NEG) begin : g_n
        assign t[i] = ACC_W'(-p_i[i][SEL]);
      end else begin : g_p
        assign t[i] = p_i[i][SEL];
      end
    end

    assign l1_lo  = t[0] + t[1];
    assign l1_hi  = t[2] + t[3];
    assign o_o[k] = l1_lo + l1_hi;
  end

endmodule

// File: rtl/dct8_fwd.sv
module dct8_fwd #(
  parameter int DATA_W = 16,
  localparam int OUT_W = DATA_W + dct8_pkg::GROWTH
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               valid_i,
  input  logic [dct8_pkg::N_PT-1:0][DATA_W-1:0] x_i,
  output logic                               valid_o,
  output logic [dct8_pkg::N_PT-1:0][OUT_W-1:0]  y_o
);
  import dct8_pkg::*;

  logic [N_HALF-1:0][OUT_W-1:0]             a_w, b_w, even_w, odd_w;
  logic [N_HALF-1:0][N_HALF-1:0][OUT_W-1:0] prod_w;
  logic [N_PT-1:0][OUT_W-1:0]               y_c, y_q;
  logic                                     valid_q;

  dct8_butterfly #(.IN_W(DATA_W), .ACC_W(OUT_W)) u_fold (
    .x_i (x_i),
    .a_o (a_w),
    .b_o (b_w)
  );

  dct8_even4 #(.ACC_W(OUT_W)) u_even (
    .a_i (a_w),
    .e_o (even_w)
  );

  for (genvar i = 0; i < N_HALF; i++) begin : g_mcm
    dct8_mcm #(.ACC_W(OUT_W)) u_mcm (
      .b_i (b_w[i]),
      .p_o (prod_w[i])
    );
  end

  dct8_odd_sum #(.ACC_W(OUT_W)) u_odd (
    .p_i (prod_w),
    .o_o (odd_w)
  );

  for (genvar k = 0; k < N_HALF; k++) begin : g_lane
    assign y_c[2*k]   = even_w[k];
    assign y_c[2*k+1] = odd_w[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      y_q     <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) y_q <= y_c;
    end
  end

  assign valid_o = valid_q;
  assign y_o     = y_q;

  a_r5_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid_o missed");
  a_r5_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("spurious valid_o");
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o)) else $error("y_o moved while idle");

endmodule

// File: tb/dct8_fwd_tb_top.sv
module dct8_fwd_tb_top;

  localparam int DW   = 16;
  localparam int OW   = DW + 10;
  localparam int XMAX = (1 << (DW - 1)) - 1;
  localparam int XMIN = -(1 << (DW - 1));

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 vin = 1'b0;
  logic [7:0][DW-1:0]   xin = '0;
  logic                 vout;
  logic [7:0][OW-1:0]   yout;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // Full 8x8 kernel, row k = coefficient k
  int kern [64] = '{
    64, 64, 64, 64, 64, 64, 64, 64,
    89, 75, 50, 18,-18,-50,-75,-89,
    83, 36,-36,-83,-83,-36, 36, 83,
    75,-18,-89,-50, 50, 89, 18,-75,
    64,-64,-64, 64, 64,-64,-64, 64,
    50,-89, 18, 75,-75,-18, 89,-50,
    36,-83, 83,-36,-36, 83,-83, 36,
    18,-50, 75,-89, 89,-75, 50,-18};

  longint exp_y [8];
  bit     exp_v;

  always #5 clk = ~clk;

  dct8_fwd #(.DATA_W(DW)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (vin),
    .x_i     (xin),
    .valid_o (vout),
    .y_o     (yout)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "valid_o", longint'(vout), longint'(exp_v));
    for (int k = 0; k < 8; k++)
      check(tag, $sformatf("y[%0d]", k), longint'($signed(yout[k])), exp_y[k]);
  endtask

  // Called at a falling edge; checks at the next falling edge
  task automatic apply(input bit v, input int xs[8], input string tag);
    vin = v;
    for (int n = 0; n < 8; n++) xin[n] = DW'(xs[n]);
    exp_v = v;
    if (v) begin
      for (int k = 0; k < 8; k++) begin
        longint acc = 0;
        for (int n = 0; n < 8; n++) acc += longint'(kern[k*8+n]) * longint'(xs[n]);
        exp_y[k] = acc;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int xs[8];
    foreach (exp_y[k]) exp_y[k] = 0;
    exp_v = 1'b0;

    // R7: reset state with busy inputs
    vin = 1'b1;
    for (int n = 0; n < 8; n++) xin[n] = DW'(n * 1000 + 7);
    repeat (3) @(negedge clk);
    compare_all("R7");
    vin = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: impulse on each lane gives kernel column
    for (int j = 0; j < 8; j++) begin
      foreach (xs[n]) xs[n] = 0;
      xs[j] = 1;
      apply(1'b1, xs, "R2_R3_impulse");
    end

    // R1: mirrored column -> odd lanes zero
    foreach (xs[n]) xs[n] = 0;
    for (int i = 0; i < 4; i++) begin xs[i] = 100 * (i + 1) - 333; xs[7-i] = xs[i]; end
    apply(1'b1, xs, "R1_mirror");
    for (int k = 1; k < 8; k += 2) check("R1", "odd zero", longint'($signed(yout[k])), 0);

    // R1: anti-mirrored column -> even lanes zero
    for (int i = 0; i < 4; i++) begin xs[i] = 57 * (i + 2) - 400; xs[7-i] = -xs[i]; end
    apply(1'b1, xs, "R1_antimirror");
    for (int k = 0; k < 8; k += 2) check("R1", "even zero", longint'($signed(yout[k])), 0);

    // R4: extremes
    foreach (xs[n]) xs[n] = XMAX;
    apply(1'b1, xs, "R4_all_max");
    foreach (xs[n]) xs[n] = XMIN;
    apply(1'b1, xs, "R4_all_min");
    for (int k = 0; k < 8; k++) begin
      foreach (xs[n]) xs[n] = (kern[k*8+n] > 0) ? XMIN : XMAX;
      apply(1'b1, xs, "R4_row_min");
      foreach (xs[n]) xs[n] = (kern[k*8+n] > 0) ? XMAX : XMIN;
      apply(1'b1, xs, "R4_row_max");
    end

    // R6: idle cycles with changing inputs keep the last result
    for (int c = 0; c < 6; c++) begin
      foreach (xs[n]) xs[n] = rnd_s();
      apply(1'b0, xs, "R6_hold");
    end

    // R5: toggling valid, R2/R3 random data
    for (int c = 0; c < 300; c++) begin
      foreach (xs[n]) xs[n] = rnd_s();
      apply((c % 3) != 2, xs, "R5_R2_R3_random");
    end

    // R5: back-to-back stream
    for (int c = 0; c < 200; c++) begin
      foreach (xs[n]) xs[n] = rnd_s();
      apply(1'b1, xs, "R5_stream");
    end

    // R7: reset in mid-stream clears outputs
    rst_n = 1'b0;
    exp_v = 1'b0;
    foreach (exp_y[k]) exp_y[k] = 0;
    #2;
    compare_all("R7_midrun");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule